// File: doc/BRIEF.md
# Three-Wire Bus Arbitration Requester

This block lets a secondary master, such as an accelerator built into programmable logic, borrow a 68000-style bus from the resident processor. It uses the three-line handshake of request, grant and grant-acknowledge. A local client raises a request level. The block pulls the request line low. It waits for the processor's grant and then for the processor's current bus cycle to end, which it sees as both the address strobe and the data acknowledge going high. It then turns the external level-shifting transceivers toward the processor side. One clock later it pulls grant-acknowledge low and lets go of the request line.

While grant-acknowledge is held, the block reports that it owns the bus, and the local side runs its own transfers. A one-cycle local done pulse releases grant-acknowledge. The transceivers return to the input direction on the following clock. The block then waits for the processor's grant to go high before it will accept a new request.

Both handshake lines are shared open-drain wires. The block therefore brings out only "pull low" enables for them, and a deasserted enable means the pin is left at high impedance. The grant-acknowledge wire is also sampled back as an input.

Top module: `busArbRequester`

## Requirements
- R1: A synchronous active-high reset sets brDriveLow, gackDriveLow, busOwned and xcvrToCpu to 0. A reset asserted while the bus is owned also drops ownership at the next clock edge.
- R2: In the idle state, when reqLocal is 1 and the synchronized gackInN is 1, brDriveLow goes to 1 at the next clock edge.
- R3: While gackInN is 0 (another master holds the bus), no request starts, even with reqLocal held at 1. Once gackInN returns to 1, brDriveLow rises on the third clock edge, counted from the edge following the input change.
- R4: grantInN, strobeInN, ackInN and gackInN each pass through two flops before the state machine uses them. Let grant go low before edge 1, and let strobe and ack go high before edges a+1 and b+1 (a value of 0 means already high). xcvrToCpu then rises at edge max(4, max(a,b)+3).
- R5: gackDriveLow rises exactly one edge after xcvrToCpu rises. brDriveLow falls at that same edge.
- R6: busOwned is 1 exactly while gackDriveLow is 1. It stays 1 after the processor negates grant, until done.
- R7: A doneLocal pulse during ownership clears gackDriveLow and busOwned at the next edge. xcvrToCpu falls one edge after that.
- R8: After release, the block raises no new request while grantInN stays 0. Once grantInN goes to 1 with reqLocal at 1, brDriveLow rises at the fourth edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqLocal | input | 1 | Local side wants the bus (level) |
| doneLocal | input | 1 | Local transfers finished (one-cycle pulse) |
| grantInN | input | 1 | Processor bus grant, active low, asynchronous |
| strobeInN | input | 1 | Processor address strobe, active low, asynchronous |
| ackInN | input | 1 | Data acknowledge, active low, asynchronous |
| gackInN | input | 1 | Sampled grant-acknowledge wire, active low, asynchronous |
| brDriveLow | output | 1 | 1 pulls the bus request wire low; 0 leaves it at high impedance |
| gackDriveLow | output | 1 | 1 pulls the grant-acknowledge wire low; 0 leaves it at high impedance |
| busOwned | output | 1 | The requester holds the bus |
| xcvrToCpu | output | 1 | Transceiver direction: 1 drives toward the processor, 0 is input |

## Verification
The takeover is swept over every pair of end times for the processor's strobe and acknowledge, from 0 to 4 cycles after the grant. This covers three situations: the bus is already idle, one signal ends late, and the other ends late. The exact edges at which the direction flip and grant-acknowledge occur show that the block waits for both signals, not just one, and that it keeps the two-flop latency. Separate runs hold the grant-acknowledge wire low to mimic a foreign master, keep grant low after release to exercise the release hold, and reset in the middle of ownership.

// File: rtl/busArbPkg.sv
package busArbPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQUEST,
    ST_WAIT_IDLE,
    ST_OWN,
    ST_RELEASE
  } arbState_t;

  // One-cycle commands from control to the output register bank
  typedef struct packed {
    logic setBr;
    logic clrBr;
    logic setDir;
    logic clrDir;
    logic setGack;
    logic clrGack;
  } arbStrobes_t;

  localparam int unsigned SYNC_LINES = 4;

endpackage

// File: rtl/busArbSync.sv
module busArbSync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] stageQ [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stageQ[gi] <= '1;
          else     stageQ[gi] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stageQ[gi] <= '1;
          else     stageQ[gi] <= stageQ[gi-1];
        end
      end
    end
  endgenerate

  assign syncOut = stageQ[LAST];

endmodule

// File: rtl/busArbCtrl.sv
module busArbCtrl
  import busArbPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqLocal,
  input  logic        doneLocal,
  input  logic        sGrantN,
  input  logic        sStrobeN,
  input  logic        sAckN,
  input  logic        sGackN,
  input  logic        dirNow,
  output arbStrobes_t stb
);

  arbState_t state, nextState;
  logic      busIdle;

  assign busIdle = sStrobeN && sAckN;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqLocal && sGackN) begin
          stb.setBr = 1'b1;
          nextState = ST_REQUEST;
        end
      end
      ST_REQUEST: begin
        if (!sGrantN) nextState = ST_WAIT_IDLE;
      end
      ST_WAIT_IDLE: begin
        if (dirNow) begin
          stb.setGack = 1'b1;
          stb.clrBr   = 1'b1;
          nextState   = ST_OWN;
        end else if (busIdle) begin
          stb.setDir = 1'b1;
        end
      end
      ST_OWN: begin
        if (doneLocal) begin
          stb.clrGack = 1'b1;
          nextState   = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        stb.clrDir = 1'b1;
        if (sGrantN) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R3
  foreign_master_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !sGackN) |=> (state == ST_IDLE));

  // R4
  idle_bus_before_flip_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dirNow) |-> $past(sStrobeN && sAckN));

  // R8
  release_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RELEASE && !sGrantN) |=> (state == ST_RELEASE));

endmodule

// File: rtl/busArbPath.sv
module busArbPath
  import busArbPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  arbStrobes_t stb,
  output logic        brDrv,
  output logic        gackDrv,
  output logic        dirReg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      brDrv   <= 1'b0;
      gackDrv <= 1'b0;
      dirReg  <= 1'b0;
    end else begin
      if (stb.setBr)        brDrv   <= 1'b1;
      else if (stb.clrBr)   brDrv   <= 1'b0;
      if (stb.setGack)      gackDrv <= 1'b1;
      else if (stb.clrGack) gackDrv <= 1'b0;
      if (stb.setDir)       dirReg  <= 1'b1;
      else if (stb.clrDir)  dirReg  <= 1'b0;
    end
  end

  // R1
  reset_release_chk: assert property (@(posedge clk)
    rst |=> (!brDrv && !gackDrv && !dirReg));

  // R5
  dir_before_gack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gackDrv) |-> (dirReg && $past(dirReg)));

  // R5
  no_req_while_owned_chk: assert property (@(posedge clk) disable iff (rst)
    gackDrv |-> !brDrv);

  // R7
  dir_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(gackDrv) |=> !dirReg);

endmodule

// File: rtl/busArbRequester.sv
module busArbRequester
  import busArbPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic reqLocal,
  input  logic doneLocal,
  input  logic grantInN,
  input  logic strobeInN,
  input  logic ackInN,
  input  logic gackInN,
  output logic brDriveLow,
  output logic gackDriveLow,
  output logic busOwned,
  output logic xcvrToCpu
);

  logic [SYNC_LINES-1:0] rawIn, syncIn;
  arbStrobes_t           stb;
  logic                  dirReg, gackDrv, brDrv;

  assign rawIn = {gackInN, ackInN, strobeInN, grantInN};

  busArbSync #(.WIDTH(SYNC_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn (rawIn),
    .syncOut (syncIn)
  );

  busArbCtrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .reqLocal  (reqLocal),
    .doneLocal (doneLocal),
    .sGrantN   (syncIn[0]),
    .sStrobeN  (syncIn[1]),
    .sAckN     (syncIn[2]),
    .sGackN    (syncIn[3]),
    .dirNow    (dirReg),
    .stb       (stb)
  );

  busArbPath u_path (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .brDrv   (brDrv),
    .gackDrv (gackDrv),
    .dirReg  (dirReg)
  );

  assign brDriveLow   = brDrv;
  assign gackDriveLow = gackDrv;
  assign busOwned     = gackDrv;
  assign xcvrToCpu    = dirReg;

  // R6
  owned_matches_gack_chk: assert property (@(posedge clk) disable iff (rst)
    busOwned == gackDriveLow);

endmodule

// File: tb/test_busArbRequester.sv
module test_busArbRequester;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqLocal = 1'b0, doneLocal = 1'b0;
  logic grantInN = 1'b1, strobeInN = 1'b1, ackInN = 1'b1, gackInN = 1'b1;
  logic brDriveLow, gackDriveLow, busOwned, xcvrToCpu;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  busArbRequester i_busArbRequester (
    .clk(clk), .rst(rst), .reqLocal(reqLocal), .doneLocal(doneLocal),
    .grantInN(grantInN), .strobeInN(strobeInN), .ackInN(ackInN),
    .gackInN(gackInN), .brDriveLow(brDriveLow), .gackDriveLow(gackDriveLow),
    .busOwned(busOwned), .xcvrToCpu(xcvrToCpu)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Raise request and wait for the request line to be pulled low
  task automatic wait_br();
    for (int i = 0; i < 20 && !brDriveLow; i++) @(negedge clk);
  endtask

  // Takeover with strobe busy a cycles and ack busy b cycles after grant
  task automatic takeover(input int a, input int b);
    int dirAt, gackAt, expDir, m;
    bit brAtGack, ownAtGack;
    reqLocal  = 1'b1;
    strobeInN = (a == 0);
    ackInN    = (b == 0);
    wait_br();
    check(brDriveLow, "R2 request raised", brDriveLow, 1);
    grantInN = 1'b0;
    reqLocal = 1'b0;
    dirAt = -1; gackAt = -1; brAtGack = 1'b1; ownAtGack = 1'b0;
    for (int cyc = 1; cyc <= 30; cyc++) begin
      @(negedge clk);
      if (dirAt < 0 && xcvrToCpu) dirAt = cyc;
      if (gackAt < 0 && gackDriveLow) begin
        gackAt = cyc; brAtGack = brDriveLow; ownAtGack = busOwned;
      end
      if (cyc == a) strobeInN = 1'b1;
      if (cyc == b) ackInN = 1'b1;
    end
    m = (a > b) ? a : b;
    expDir = (m + 3 > 4) ? m + 3 : 4;
    check(dirAt == expDir, "R4 direction flip edge", dirAt, expDir);
    check(gackAt == expDir + 1, "R5 gack edge", gackAt, expDir + 1);
    check(!brAtGack, "R5 request dropped with gack", brAtGack, 0);
    check(ownAtGack, "R6 owned with gack", ownAtGack, 1);
  endtask

  task automatic finish_own(input bit grantBack);
    if (grantBack) grantInN = 1'b1;
    tick(3);
    check(busOwned && !brDriveLow, "R6 still owned after grant negated", busOwned, 1);
    doneLocal = 1'b1;
    @(negedge clk);
    doneLocal = 1'b0;
    check(!gackDriveLow && !busOwned, "R7 gack released", gackDriveLow, 0);
    check(xcvrToCpu, "R7 direction held one edge", xcvrToCpu, 1);
    @(negedge clk);
    check(!xcvrToCpu, "R7 direction restored", xcvrToCpu, 0);
  endtask

  initial begin
    tick(3);
    check(!brDriveLow && !gackDriveLow && !busOwned && !xcvrToCpu,
          "R1 reset state", {brDriveLow, gackDriveLow, busOwned, xcvrToCpu}, 0);
    rst = 1'b0;
    tick(2);

    // R2: request latency of one edge
    reqLocal = 1'b1;
    @(negedge clk);
    check(brDriveLow, "R2 one-edge request", brDriveLow, 1);
    rst = 1'b1; reqLocal = 1'b0; @(negedge clk); rst = 1'b0; tick(2);

    // R4 R5 R6 R7: sweep over strobe and ack end times
    for (int a = 0; a <= 4; a++) begin
      for (int b = 0; b <= 4; b++) begin
        takeover(a, b);
        finish_own(1'b1);
        tick(5);
      end
    end

    // R3: foreign master holds the grant-acknowledge wire
    gackInN = 1'b0;
    tick(3);
    reqLocal = 1'b1;
    tick(10);
    check(!brDriveLow, "R3 no request under foreign master", brDriveLow, 0);
    gackInN = 1'b1;
    tick(2);
    check(!brDriveLow, "R3 still quiet at edge 2", brDriveLow, 0);
    @(negedge clk);
    check(brDriveLow, "R3 request at edge 3", brDriveLow, 1);
    rst = 1'b1; reqLocal = 1'b0; @(negedge clk); rst = 1'b0; tick(2);

    // R8: grant kept low after release holds off a new request
    takeover(0, 0);
    reqLocal = 1'b1;
    finish_own(1'b0);
    tick(8);
    check(!brDriveLow, "R8 no request while grant low", brDriveLow, 0);
    grantInN = 1'b1;
    tick(3);
    check(!brDriveLow, "R8 quiet at edge 3", brDriveLow, 0);
    @(negedge clk);
    check(brDriveLow, "R8 request at edge 4", brDriveLow, 1);
    reqLocal = 1'b0;

    // R1: reset in the middle of ownership
    grantInN = 1'b0;
    for (int i = 0; i < 12 && !gackDriveLow; i++) @(negedge clk);
    check(gackDriveLow, "R1 owned before reset", gackDriveLow, 1);
    rst = 1'b1;
    @(negedge clk);
    check(!brDriveLow && !gackDriveLow && !busOwned && !xcvrToCpu,
          "R1 reset mid-ownership", {brDriveLow, gackDriveLow, busOwned, xcvrToCpu}, 0);
    rst = 1'b0;
    grantInN = 1'b1;
    tick(2);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule